// File: doc/BRIEF.md
# Block-Read and Writeback Transaction Tracker

This block sits on the processor side of a coherent system bus. It tracks the bus transactions raised by cache misses. A block-load miss becomes a read-to-discard request. A miss that evicts a line becomes a victimizing read, which may carry a flag marking the evicted line as dirty. Each accepted request takes a tracker entry and is placed on the bus one cycle later. System replies are applied to the outstanding reads strictly in the order the reads were issued. A data reply reports delivery. A timeout or bus-error reply reports an access error, routed to the instruction side or the data side according to the origin of the request.

A victimizing read that carries the dirty flag keeps its entry after its reply. The entry records whether another processor shares the line and whether the read failed. A later writeback to the same line then goes out on the bus together with the new duplicate-tag state for the system. That state is exclusive, shared or invalid, taken from the recorded reply. A writeback that pairs with no dirty victimizing read is refused and flagged. The number of read-to-discard requests waiting for a reply is limited by a parameter set to 1 or 2.

Top module: `cohrd_tracker`

## Requirements
- R1: After reset every entry is free, all bus and completion outputs are 0, and `req_ready` and `wb_ready` are 1.
- R2: An accepted request (`req_valid` and `req_ready` high) appears on the bus in the next cycle with `bus_cmd` 1 for a read-to-discard (`req_vict`=0) or 2 for a victimizing read (`req_vict`=1), and with `bus_addr` equal to the request address. While `bus_valid` is low, `bus_cmd`, `bus_addr` and `bus_wb_state` are 0.
- R3: A reply (`rsp_valid`) always applies to the oldest issued read still waiting for one. Code 0 pulses `done_data` in the next cycle, with `done_addr` set to that read's line.
- R4: Reply codes 1 (timeout), 2 and 3 (bus error) end the read. In the next cycle they pulse `done_ierr` if the request had `req_instr`=1, and `done_derr` otherwise. At most one of `done_data`, `done_ierr` and `done_derr` is high in any cycle.
- R5: While RDD_MAX read-to-discard requests are waiting for replies, `req_ready` is low for a further read-to-discard. A victimizing read can still be accepted.
- R6: While all NE entries are held, `req_ready` is low.
- R7: `req_dirty` has no effect on a read-to-discard. The entry is freed by its reply, and a writeback to its line is refused.
- R8: A writeback whose `wb_addr` matches a dirty victimizing read that has already been replied is accepted. It appears in the next cycle as `bus_cmd` 3 with that line address, and it frees the entry.
- R9: `bus_wb_state` on a writeback is 0 (invalid) if the paired read got an error reply, 1 (shared) if its data reply had `rsp_shared`=1, and 2 (exclusive) otherwise.
- R10: While the only matching dirty victimizing read is still waiting for its reply, `wb_ready` is low and the writeback is held.
- R11: A writeback that matches no dirty victimizing read is accepted but never issued. `wb_reject` pulses in the next cycle.
- R12: A writeback that is accepted in a cycle takes the bus in that cycle, and `req_ready` is low then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_vict | input | 1 | 1 = victimizing read, 0 = read-to-discard |
| req_addr | input | AW | Line address of the request |
| req_instr | input | 1 | Request comes from the instruction side |
| req_dirty | input | 1 | Victim line is dirty (used only by victimizing reads) |
| req_ready | output | 1 | Request can be accepted this cycle |
| wb_valid | input | 1 | Writeback request present |
| wb_addr | input | AW | Line address of the writeback |
| wb_ready | output | 1 | Writeback is consumed this cycle |
| wb_reject | output | 1 | Unpaired writeback was refused |
| bus_valid | output | 1 | Bus request issued |
| bus_cmd | output | 2 | 1 read-to-discard, 2 victimizing read, 3 writeback |
| bus_addr | output | AW | Line address on the bus |
| bus_wb_state | output | 2 | Duplicate-tag state with a writeback: 0 I, 1 S, 2 E |
| rsp_valid | input | 1 | System reply present |
| rsp_code | input | 2 | 0 data, 1 timeout, 2 or 3 bus error |
| rsp_shared | input | 1 | Another processor shares the line |
| done_data | output | 1 | Read completed with data |
| done_ierr | output | 1 | Instruction access error |
| done_derr | output | 1 | Data access error |
| done_addr | output | AW | Line address of the completed read |

## Verification
The bench builds the tracker with four entries, a cap of two read-to-discard requests and 12-bit addresses. With these values, a few requests are enough to hit both the per-type cap and a full table. That makes both stalls, and the case where a victimizing read passes a capped read-to-discard, reachable in directed sequences. Random traffic then mixes reply codes, shared indications, held and refused writebacks, and requests that arrive in the same cycle as a writeback. A queue model is compared against the design in every cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;
   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_PEND = 2'd1,
      ST_WAIT = 2'd2
   } ent_st_e;

   localparam logic [1:0] CMD_IDLE = 2'd0;
   localparam logic [1:0] CMD_RDD  = 2'd1;
   localparam logic [1:0] CMD_VRD  = 2'd2;
   localparam logic [1:0] CMD_WRB  = 2'd3;

   localparam logic [1:0] RSP_DATA = 2'd0;

   localparam logic [1:0] TAG_I = 2'd0;
   localparam logic [1:0] TAG_S = 2'd1;
   localparam logic [1:0] TAG_E = 2'd2;
endpackage

// File: rtl/crt_first_set.sv
module crt_first_set #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/crt_addr_cam.sv
module crt_addr_cam #(
   parameter int N  = 4,
   parameter int AW = 32
) (
   input  logic [N-1:0][AW-1:0] tags,
   input  logic [AW-1:0]        key,
   output logic [N-1:0]         hit
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit[g] = (tags[g] == key);
   end
endmodule

// File: rtl/crt_idx_fifo.sv
module crt_idx_fifo #(
   parameter int DEPTH = 4,
   parameter int IW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [IW-1:0] push_idx,
   input  logic          pop,
   output logic          empty,
   output logic [IW-1:0] head
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [IW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   assign empty = (cnt_q == '0);
   assign head  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
         if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/cohrd_tracker.sv
module cohrd_tracker
   import crt_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NE      = 4,
   parameter int RDD_MAX = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_vict,
   input  logic [AW-1:0] req_addr,
   input  logic          req_instr,
   input  logic          req_dirty,
   output logic          req_ready,
   input  logic          wb_valid,
   input  logic [AW-1:0] wb_addr,
   output logic          wb_ready,
   output logic          wb_reject,
   output logic          bus_valid,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_wb_state,
   input  logic          rsp_valid,
   input  logic [1:0]    rsp_code,
   input  logic          rsp_shared,
   output logic          done_data,
   output logic          done_ierr,
   output logic          done_derr,
   output logic [AW-1:0] done_addr
);
   localparam int IW = (NE > 1) ? $clog2(NE) : 1;
   localparam int CW = $clog2(NE + 1);

   if (NE < 2) begin : g_bad_depth
      $error("cohrd_tracker: NE must be at least 2");
   end
   if (RDD_MAX != 1 && RDD_MAX != 2) begin : g_bad_cap
      $error("cohrd_tracker: RDD_MAX must be 1 or 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("cohrd_tracker: AW must be positive");
   end

   ent_st_e             st_q [NE];
   logic [NE-1:0][AW-1:0] addr_q;
   logic [NE-1:0]       vict_q, instr_q, dirty_q, shared_q, fail_q;

   logic [NE-1:0] free_v, wait_v, pdirty_v, prdd_v;
   logic [NE-1:0] addr_hit, hit_wait, hit_pend;
   logic [CW-1:0] rdd_cnt;
   logic          rdd_full;

   for (genvar g = 0; g < NE; g++) begin : g_ent
      assign free_v[g]   = (st_q[g] == ST_FREE);
      assign wait_v[g]   = (st_q[g] == ST_WAIT);
      assign pdirty_v[g] = (st_q[g] == ST_PEND) && vict_q[g] && dirty_q[g];
      assign prdd_v[g]   = (st_q[g] == ST_PEND) && !vict_q[g];
   end

   assign rdd_cnt = CW'($countones(prdd_v));

   if (RDD_MAX == 1) begin : g_cap_one
      assign rdd_full = (rdd_cnt != '0);
   end else begin : g_cap_many
      assign rdd_full = (rdd_cnt >= CW'(RDD_MAX));
   end

   crt_addr_cam #(.N(NE), .AW(AW)) u_cam (
      .tags (addr_q),
      .key  (wb_addr),
      .hit  (addr_hit)
   );
   assign hit_wait = addr_hit & wait_v;
   assign hit_pend = addr_hit & pdirty_v;

   logic          alloc_ok, wb_hit;
   logic [IW-1:0] alloc_idx, wb_idx;

   crt_first_set #(.N(NE), .IW(IW)) u_alloc (
      .vec   (free_v),
      .found (alloc_ok),
      .idx   (alloc_idx)
   );
   crt_first_set #(.N(NE), .IW(IW)) u_wbsel (
      .vec   (hit_wait),
      .found (wb_hit),
      .idx   (wb_idx)
   );

   logic          rsp_fire, fifo_empty, rsp_err, rsp_keep;
   logic [IW-1:0] head_idx;
   logic          req_fire, wb_take, wb_rej;

   assign wb_ready  = wb_hit || !(|hit_pend);
   assign wb_take   = wb_valid && wb_hit;
   assign wb_rej    = wb_valid && !wb_hit && !(|hit_pend);
   assign req_ready = alloc_ok && (req_vict || !rdd_full) && !wb_take;
   assign req_fire  = req_valid && req_ready;

   crt_idx_fifo #(.DEPTH(NE), .IW(IW)) u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (req_fire),
      .push_idx (alloc_idx),
      .pop      (rsp_fire),
      .empty    (fifo_empty),
      .head     (head_idx)
   );

   assign rsp_fire = rsp_valid && !fifo_empty;
   assign rsp_err  = (rsp_code != RSP_DATA);
   assign rsp_keep = vict_q[head_idx] && dirty_q[head_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NE; i++) st_q[i] <= ST_FREE;
      end else begin
         if (rsp_fire) begin
            if (rsp_keep) begin
               st_q[head_idx]     <= ST_WAIT;
               shared_q[head_idx] <= rsp_shared;
               fail_q[head_idx]   <= rsp_err;
            end else begin
               st_q[head_idx] <= ST_FREE;
            end
         end
         if (wb_take) st_q[wb_idx] <= ST_FREE;
         if (req_fire) begin
            st_q[alloc_idx]    <= ST_PEND;
            addr_q[alloc_idx]  <= req_addr;
            vict_q[alloc_idx]  <= req_vict;
            instr_q[alloc_idx] <= req_instr;
            dirty_q[alloc_idx] <= req_vict && req_dirty;
         end
      end
   end

   logic [1:0] wb_state;
   always_comb begin
      if (fail_q[wb_idx])        wb_state = TAG_I;
      else if (shared_q[wb_idx]) wb_state = TAG_S;
      else                       wb_state = TAG_E;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_valid    <= 1'b0;
         bus_cmd      <= CMD_IDLE;
         bus_addr     <= '0;
         bus_wb_state <= TAG_I;
         wb_reject    <= 1'b0;
         done_data    <= 1'b0;
         done_ierr    <= 1'b0;
         done_derr    <= 1'b0;
         done_addr    <= '0;
      end else begin
         bus_valid <= wb_take || req_fire;
         wb_reject <= wb_rej;
         if (wb_take) begin
            bus_cmd      <= CMD_WRB;
            bus_addr     <= addr_q[wb_idx];
            bus_wb_state <= wb_state;
         end else if (req_fire) begin
            bus_cmd      <= req_vict ? CMD_VRD : CMD_RDD;
            bus_addr     <= req_addr;
            bus_wb_state <= TAG_I;
         end else begin
            bus_cmd      <= CMD_IDLE;
            bus_addr     <= '0;
            bus_wb_state <= TAG_I;
         end
         done_data <= rsp_fire && !rsp_err;
         done_ierr <= rsp_fire && rsp_err && instr_q[head_idx];
         done_derr <= rsp_fire && rsp_err && !instr_q[head_idx];
         done_addr <= rsp_fire ? addr_q[head_idx] : '0;
      end
   end
endmodule

// File: rtl/cohrd_tracker_chk.sv
module cohrd_tracker_chk
   import crt_pkg::*;
#(
   parameter int NE      = 4,
   parameter int RDD_MAX = 2,
   parameter int CW      = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          wb_valid,
   input logic          wb_ready,
   input logic          wb_reject,
   input logic          bus_valid,
   input logic [1:0]    bus_cmd,
   input logic [1:0]    bus_wb_state,
   input logic          done_data,
   input logic          done_ierr,
   input logic          done_derr,
   input logic [NE-1:0] free_v,
   input logic [CW-1:0] rdd_cnt
);
   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (bus_cmd == CMD_IDLE && bus_wb_state == TAG_I));

   assert_req_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bus_valid && bus_cmd != CMD_WRB));

   assert_done_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_data, done_ierr, done_derr}));

   assert_rdd_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rdd_cnt <= CW'(RDD_MAX));

   assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (free_v == '0) |-> !req_ready);

   assert_wb_from_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == CMD_WRB) |-> $past(wb_valid && wb_ready));

   assert_wb_state_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_WRB) |-> (bus_wb_state != 2'd3));

   assert_reject_nobus_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_reject |-> ($past(wb_valid) && bus_cmd != CMD_WRB));
endmodule

bind cohrd_tracker cohrd_tracker_chk #(
   .NE      (NE),
   .RDD_MAX (RDD_MAX),
   .CW      ($clog2(NE + 1))
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .wb_valid     (wb_valid),
   .wb_ready     (wb_ready),
   .wb_reject    (wb_reject),
   .bus_valid    (bus_valid),
   .bus_cmd      (bus_cmd),
   .bus_wb_state (bus_wb_state),
   .done_data    (done_data),
   .done_ierr    (done_ierr),
   .done_derr    (done_derr),
   .free_v       (free_v),
   .rdd_cnt      (rdd_cnt)
);

// File: tb/sim_cohrd_tracker.sv
module sim_cohrd_tracker;
   localparam int AW   = 12;
   localparam int NE   = 4;
   localparam int RMAX = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 0, req_vict = 0, req_instr = 0, req_dirty = 0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready;
   logic          wb_valid = 0;
   logic [AW-1:0] wb_addr = '0;
   logic          wb_ready, wb_reject;
   logic          bus_valid;
   logic [1:0]    bus_cmd, bus_wb_state;
   logic [AW-1:0] bus_addr;
   logic          rsp_valid = 0, rsp_shared = 0;
   logic [1:0]    rsp_code = '0;
   logic          done_data, done_ierr, done_derr;
   logic [AW-1:0] done_addr;

   always #5 clk = ~clk;

   cohrd_tracker #(.AW(AW), .NE(NE), .RDD_MAX(RMAX)) u0 (.*);

   typedef struct {
      logic [AW-1:0] a;
      bit v, i, d;
      int st;
      bit sh, fl;
   } ent_t;

   ent_t mq[$];
   int   n_chk = 0, n_fail = 0;
   int   nv = 0;
   logic          e_bv = 0, e_rej = 0, e_dd = 0, e_di = 0, e_dr = 0;
   logic [1:0]    e_cmd = 0, e_st = 0;
   logic [AW-1:0] e_baddr = 0, e_daddr = 0;

   task automatic chk(input string r, input string f, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, f, act, exp);
      end
   endtask

   task automatic step(input bit rv, input bit rk, input logic [AW-1:0] ra, input bit ri, input bit rd,
                       input bit wv, input logic [AW-1:0] wa,
                       input bit pv, input logic [1:0] pc, input bit ps);
      int  hw, p, rc, dp;
      bit  hp, wrdy, wtake, wrej, rrdy;
      ent_t ne;
      @(negedge clk);
      chk("R2", "bus_valid", bus_valid, e_bv);
      chk("R2", "bus_cmd", bus_cmd, e_cmd);
      chk("R2", "bus_addr", bus_addr, e_baddr);
      chk("R9", "bus_wb_state", bus_wb_state, e_st);
      chk("R11", "wb_reject", wb_reject, e_rej);
      chk("R3", "done_data", done_data, e_dd);
      chk("R4", "done_ierr", done_ierr, e_di);
      chk("R4", "done_derr", done_derr, e_dr);
      chk("R3", "done_addr", done_addr, e_daddr);
      req_valid = rv; req_vict = rk; req_addr = ra; req_instr = ri; req_dirty = rd;
      wb_valid = wv; wb_addr = wa;
      rsp_valid = pv; rsp_code = pc; rsp_shared = ps;
      #1;
      hw = -1; p = -1; rc = 0; hp = 0;
      foreach (mq[k]) begin
         if (mq[k].st == 2 && mq[k].a == wa && hw < 0) hw = k;
         if (mq[k].st == 1 && mq[k].v && mq[k].d && mq[k].a == wa) hp = 1;
         if (mq[k].st == 1 && !mq[k].v) rc++;
         if (mq[k].st == 1 && p < 0) p = k;
      end
      wrdy  = (hw >= 0) || !hp;
      wtake = wv && hw >= 0;
      wrej  = wv && hw < 0 && !hp;
      rrdy  = (mq.size() < NE) && (rk || rc < RMAX) && !wtake;
      if (wtake)                  chk("R12", "req_ready", req_ready, rrdy);
      else if (mq.size() >= NE)   chk("R6", "req_ready", req_ready, rrdy);
      else if (!rk && rc >= RMAX) chk("R5", "req_ready", req_ready, rrdy);
      else                        chk("R2", "req_ready", req_ready, rrdy);
      chk("R10", "wb_ready", wb_ready, wrdy);
      // expected bus outputs for the next cycle
      e_bv = wtake || (rv && rrdy);
      if (wtake) begin
         e_cmd = 2'd3; e_baddr = mq[hw].a;
         e_st  = mq[hw].fl ? 2'd0 : (mq[hw].sh ? 2'd1 : 2'd2);
      end else if (rv && rrdy) begin
         e_cmd = rk ? 2'd2 : 2'd1; e_baddr = ra; e_st = 2'd0;
      end else begin
         e_cmd = 2'd0; e_baddr = '0; e_st = 2'd0;
      end
      e_rej = wrej;
      dp = -1;
      if (pv && p >= 0) begin
         e_dd = (pc == 2'd0);
         e_di = (pc != 2'd0) && mq[p].i;
         e_dr = (pc != 2'd0) && !mq[p].i;
         e_daddr = mq[p].a;
         if (mq[p].v && mq[p].d) begin
            mq[p].st = 2; mq[p].sh = ps; mq[p].fl = (pc != 2'd0);
         end else dp = p;
      end else begin
         e_dd = 0; e_di = 0; e_dr = 0; e_daddr = '0;
      end
      if (!wtake) hw = -1;
      if (dp > hw) begin
         mq.delete(dp);
         if (hw >= 0) mq.delete(hw);
      end else begin
         if (hw >= 0) mq.delete(hw);
         if (dp >= 0) mq.delete(dp);
      end
      if (rv && rrdy) begin
         ne.a = ra; ne.v = rk; ne.i = ri; ne.d = rk && rd; ne.st = 1; ne.sh = 0; ne.fl = 0;
         mq.push_back(ne);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, '0, 0, 0, 0, '0, 0, 2'd0, 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", "bus_valid", bus_valid, 0);
      chk("R1", "done_any", {done_data, done_ierr, done_derr}, 0);
      chk("R1", "req_ready", req_ready, 1);
      chk("R1", "wb_ready", wb_ready, 1);
      // R2 R5 R7: two read-to-discards (one with dirty set), third capped
      step(1, 0, 12'h010, 0, 1, 0, '0, 0, 0, 0);
      step(1, 0, 12'h011, 1, 0, 0, '0, 0, 0, 0);
      step(1, 0, 12'h012, 0, 0, 0, '0, 0, 0, 0);
      // R5: victimizing read passes the capped type
      step(1, 1, 12'h100, 0, 1, 0, '0, 0, 0, 0);
      step(1, 1, 12'h101, 0, 0, 0, '0, 0, 0, 0);
      // R6: table full
      step(1, 1, 12'h102, 0, 1, 0, '0, 0, 0, 0);
      // R10: writeback held while paired read waits
      step(0, 0, '0, 0, 0, 1, 12'h100, 0, 0, 0);
      // R3 R4: replies in issue order
      step(0, 0, '0, 0, 0, 0, '0, 1, 2'd0, 0);
      step(0, 0, '0, 0, 0, 0, '0, 1, 2'd1, 0);
      step(0, 0, '0, 0, 0, 0, '0, 1, 2'd0, 1);
      step(0, 0, '0, 0, 0, 0, '0, 1, 2'd2, 0);
      // R7 R11: writeback to a read-to-discard line refused
      step(0, 0, '0, 0, 0, 1, 12'h010, 0, 0, 0);
      // R8 R9 R12: writeback (shared) beats a request
      step(1, 0, 12'h020, 0, 0, 1, 12'h100, 0, 0, 0);
      idle(1);
      // R9: exclusive and invalid outcomes
      step(1, 1, 12'h103, 0, 1, 0, '0, 0, 0, 0);
      step(0, 0, '0, 0, 0, 0, '0, 1, 2'd0, 0);
      step(0, 0, '0, 0, 0, 1, 12'h103, 0, 0, 0);
      step(1, 1, 12'h104, 1, 1, 0, '0, 0, 0, 0);
      step(0, 0, '0, 0, 0, 0, '0, 1, 2'd3, 1);
      step(0, 0, '0, 0, 0, 1, 12'h104, 0, 0, 0);
      idle(2);
      // mixed random traffic
      for (int c = 0; c < 4000; c++) begin
         bit rv, rk, ri, rd, wv, pv, ps;
         logic [AW-1:0] ra, wa;
         logic [1:0] pc;
         int cand[$];
         rv = ($urandom % 2) == 0;
         rk = ($urandom % 2) == 0;
         ri = $urandom % 2;
         rd = $urandom % 2;
         if (rk && rd) begin
            ra = AW'(12'h100 + (nv % 12'h600));
            nv++;
         end else ra = AW'($urandom % 256);
         wv = ($urandom % 10) < 3;
         cand.delete();
         foreach (mq[k]) if (mq[k].v && mq[k].d) cand.push_back(k);
         if (cand.size() > 0 && ($urandom % 10) < 7) wa = mq[cand[$urandom % cand.size()]].a;
         else wa = AW'(12'hF00 | ($urandom % 256));
         pv = ($urandom % 10) < 4;
         pc = ($urandom % 3 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
         ps = $urandom % 2;
         step(rv, rk, ra, ri, rd, wv, wa, pv, pc, ps);
      end
      idle(2);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule